// File: doc/BRIEF.md
# Serial audio output formatter

This block sits behind a digital audio receiver's decoder. It takes decoded stereo samples, one channel at a time, and puts them out on a three-wire serial audio link: data, bit clock and left/right clock. Two oversampled master clocks go with the link. Each incoming sample arrives with a channel select and an error flag. A flagged sample is dropped, and that channel keeps sending its last good value, so a glitch on the line becomes a repeated sample rather than a click.

A mode input picks the word format. One format sends 20-bit words least significant bit first. The other sends the upper 16 bits of each word most significant bit first.

All timing comes from one base clock running at 768 times the sample rate. This is twice the 384x master rate, so that the 256x clock can be formed with a 2:1 high:low duty using rising edges only. A frame is 64 bit-clock periods, with 32 bit slots per channel. A lock input marks whether the upstream clock recovery is locked. While it is low, the data line and both master clocks are quiet, and the stored samples are protected.

Top module: `sof_serial_out`

## Requirements
- R1: While the latched format is 1, channel slot k (k = 0..19) carries bit k of that channel's word, so the LSB goes first. Slots 20..31 are low.
- R2: While the latched format is 0, channel slot k (k = 0..15) carries bit 19-k of the 20-bit word, so the top 16 bits go MSB first. Slots 16..31 are low.
- R3: The bit clock has a period of 12 base cycles. It is low for the first 6 cycles of a slot and high for the last 6. The data line changes only where the bit clock falls.
- R4: A frame has 64 slots. The left/right clock is high for slots 0..31, which carry the left channel (inChan=0). It is low for slots 32..63, which carry the right channel (inChan=1).
- R5: A strobed sample with inErr=1 is discarded, and its channel keeps its last good word. Each channel has its own held word, and both reset to zero.
- R6: The held words and the format input are captured together at each frame start. A change on modeSel or on the held words shows up only from the next frame.
- R7: The 384x clock output toggles on every base cycle while lock is high.
- R8: The 256x clock output repeats every 3 base cycles, high for 2 and low for 1, while lock is high.
- R9: While lockIn is low, the data line and both master clock outputs are low. Strobed samples are ignored. The bit clock and the left/right clock keep running.
- R10: In reset, the bit clock, data line and master clocks are low (with lock low), and the left/right clock is high. After reset the latched format is 0 and both transmit words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, 768 x sample rate |
| rstN | input | 1 | Active-low synchronous reset |
| lockIn | input | 1 | Upstream clock recovery locked |
| modeSel | input | 1 | 1 = 20-bit LSB first, 0 = 16-bit MSB first |
| inStb | input | 1 | Sample strobe |
| inChan | input | 1 | 0 = left, 1 = right |
| inData | input | 20 | Sample word |
| inErr | input | 1 | Sample flagged erroneous |
| sdataOut | output | 1 | Serial data |
| bclkOut | output | 1 | Bit clock |
| lrckOut | output | 1 | Left/right clock |
| mclk384Out | output | 1 | 384 x sample-rate clock |
| mclk256Out | output | 1 | 256 x sample-rate clock, 2:1 duty |

## Verification
The bench keeps a behavioural model that counts base cycles since reset and compares every output on every cycle. Samples arrive mid-frame and alternate between channels. Runs of error flags cover one channel twice in a row and both channels back to back; this separates per-channel hold from a shared hold or no hold at all. The format input is toggled in the middle of frames, which tells a frame-aligned switch apart from an immediate one. It also checks both bit orders against the same held words. A stretch without lock, with samples strobed during it, shows whether those samples leak into the words held once lock returns.

// File: rtl/sof_pkg.sv
package sof_pkg;
  localparam int SLOT_W = 6;

  typedef struct packed {
    logic              frameLoad;
    logic [SLOT_W-1:0] slot;
  } strobe_t;
endpackage

// File: rtl/sof_ctrl.sv
module sof_ctrl
  import sof_pkg::*;
#(
  parameter int BCLK_DIV = 12,
  parameter int SLOTS    = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    lockIn,
  output strobe_t strb,
  output logic    bclkOut,
  output logic    lrckOut,
  output logic    mclk384Out,
  output logic    mclk256Out
);
  localparam int PH_W = $clog2(BCLK_DIV);
  localparam int HALF = BCLK_DIV / 2;
  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(BCLK_DIV - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  logic [PH_W-1:0]   phaseCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic              div2;
  logic [1:0]        div3;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      slotCnt  <= '0;
      div2     <= 1'b0;
      div3     <= 2'd0;
    end else begin
      phaseCnt <= (phaseCnt == PH_LAST) ? '0 : phaseCnt + 1'b1;
      if (phaseCnt == PH_LAST)
        slotCnt <= (slotCnt == SLOT_LAST) ? '0 : slotCnt + 1'b1;
      div2 <= ~div2;
      div3 <= (div3 == 2'd2) ? 2'd0 : div3 + 2'd1;
    end
  end

  always_comb begin
    strb.frameLoad = (phaseCnt == PH_LAST) && (slotCnt == SLOT_LAST);
    strb.slot      = slotCnt;
  end

  assign bclkOut    = (phaseCnt >= PH_W'(HALF));
  assign lrckOut    = ~slotCnt[SLOT_W-1];
  assign mclk384Out = lockIn & div2;
  assign mclk256Out = lockIn & (div3 != 2'd2);

  // R8: the low phase of the 256x clock lasts a single base cycle
  a_r8_low_single: assert property (@(posedge clk) disable iff (!rstN)
    (lockIn && !mclk256Out) |=> (mclk256Out || !lockIn));
  // R7: 384x clock toggles each cycle while locked
  a_r7_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (lockIn && $past(lockIn)) |-> (mclk384Out != $past(mclk384Out)));
endmodule

// File: rtl/sof_datapath.sv
module sof_datapath
  import sof_pkg::*;
#(
  parameter int SAMPLE_W   = 20,
  parameter int LONG_W     = 20,
  parameter int SHORT_W    = 16,
  parameter int CHAN_SLOTS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lockIn,
  input  logic                modeSel,
  input  logic                inStb,
  input  logic                inChan,
  input  logic [SAMPLE_W-1:0] inData,
  input  logic                inErr,
  input  strobe_t             strb,
  output logic                sdataOut
);
  localparam int K_W = SLOT_W - 1;

  logic [SAMPLE_W-1:0] lastGood [2];
  logic [SAMPLE_W-1:0] txWord   [2];
  logic                activeMode;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lastGood[ch] <= '0;
        txWord[ch]   <= '0;
      end else begin
        if (strb.frameLoad) txWord[ch] <= lastGood[ch];
        if (lockIn && inStb && !inErr && (inChan == 1'(ch)))
          lastGood[ch] <= inData;
      end
    end

    // R5: a flagged sample leaves the channel's held word untouched
    a_r5_err_hold: assert property (@(posedge clk) disable iff (!rstN)
      (inStb && inErr && (inChan == 1'(ch))) |=> $stable(lastGood[ch]));
    // R9: nothing is stored while unlocked
    a_r9_no_store: assert property (@(posedge clk) disable iff (!rstN)
      !lockIn |=> $stable(lastGood[ch]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) activeMode <= 1'b0;
    else if (strb.frameLoad) activeMode <= modeSel;
  end

  logic           chanSel;
  logic [K_W-1:0] slotK;
  logic           bitVal;

  always_comb begin
    chanSel = strb.slot[SLOT_W-1];
    slotK   = strb.slot[K_W-1:0];
    bitVal  = 1'b0;
    if (activeMode) begin
      if (int'(slotK) < LONG_W) bitVal = txWord[chanSel][int'(slotK)];
    end else begin
      if (int'(slotK) < SHORT_W) bitVal = txWord[chanSel][SAMPLE_W - 1 - int'(slotK)];
    end
  end

  assign sdataOut = lockIn & bitVal;

  // R6: format only moves at a frame start
  a_r6_mode_frame: assert property (@(posedge clk) disable iff (!rstN)
    !strb.frameLoad |=> $stable(activeMode));
endmodule

// File: rtl/sof_serial_out.sv
module sof_serial_out
  import sof_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int LONG_W   = 20,
  parameter int SHORT_W  = 16,
  parameter int BCLK_DIV = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lockIn,
  input  logic                modeSel,
  input  logic                inStb,
  input  logic                inChan,
  input  logic [SAMPLE_W-1:0] inData,
  input  logic                inErr,
  output logic                sdataOut,
  output logic                bclkOut,
  output logic                lrckOut,
  output logic                mclk384Out,
  output logic                mclk256Out
);
  localparam int SLOTS = 2 ** SLOT_W;

  strobe_t strb;

  sof_ctrl #(.BCLK_DIV(BCLK_DIV), .SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .strb(strb),
    .bclkOut(bclkOut), .lrckOut(lrckOut),
    .mclk384Out(mclk384Out), .mclk256Out(mclk256Out)
  );

  sof_datapath #(.SAMPLE_W(SAMPLE_W), .LONG_W(LONG_W), .SHORT_W(SHORT_W),
                 .CHAN_SLOTS(SLOTS / 2)) u_dp (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .modeSel(modeSel),
    .inStb(inStb), .inChan(inChan), .inData(inData), .inErr(inErr),
    .strb(strb), .sdataOut(sdataOut)
  );

  // R3: data moves only with a falling bit clock
  a_r3_data_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdataOut) && $stable(lockIn)) |-> $fell(bclkOut));
  // R4: channel boundary sits on a bit-clock fall
  a_r4_lr_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lrckOut) |-> $fell(bclkOut));
  // R9: quiet outputs without lock
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !lockIn |-> (!sdataOut && !mclk384Out && !mclk256Out));
endmodule

// File: tb/sim_sof_serial_out.sv
module sim_sof_serial_out;
  localparam int PERIOD = 10;
  localparam int TOTAL  = 20000;

  logic clk = 1'b0;
  logic rstN, lockIn, modeSel, inStb, inChan, inErr;
  logic [19:0] inData;
  logic sdataOut, bclkOut, lrckOut, mclk384Out, mclk256Out;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  sof_serial_out u0 (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .modeSel(modeSel),
    .inStb(inStb), .inChan(inChan), .inData(inData), .inErr(inErr),
    .sdataOut(sdataOut), .bclkOut(bclkOut), .lrckOut(lrckOut),
    .mclk384Out(mclk384Out), .mclk256Out(mclk256Out)
  );

  // reference state
  int          n;
  logic [19:0] held [2];
  logic [19:0] sent [2];
  bit          fmt;

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, n, act, exp);
    end
  endtask

  task automatic compareAll();
    int ph, sl, k;
    logic w, expD;
    ph = n % 12;
    sl = (n / 12) % 64;
    k  = sl % 32;
    expD = 1'b0;
    if (fmt) begin
      if (k < 20) expD = sent[sl / 32][k];
    end else begin
      if (k < 16) expD = sent[sl / 32][19 - k];
    end
    w = lockIn & expD;
    chk("R3 bclk", bclkOut, ph >= 6);
    chk("R4 lrck", lrckOut, sl < 32);
    chk("R7 mclk384", mclk384Out, lockIn & (n % 2 == 1));
    chk("R8 mclk256", mclk256Out, lockIn & (n % 3 != 2));
    // data check also covers concealment (R5) and frame-aligned format (R6)
    if (!lockIn) chk("R9 sdata", sdataOut, 1'b0);
    else if (fmt) chk("R1 R5 R6 sdata", sdataOut, w);
    else chk("R2 R5 R6 sdata", sdataOut, w);
  endtask

  task automatic tick();
    @(posedge clk);
    if ((n + 1) % 768 == 0) begin
      sent[0] = held[0];
      sent[1] = held[1];
      fmt = modeSel;
    end
    if (lockIn && inStb && !inErr) held[inChan] = inData;
    n++;
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    rstN = 1'b0; lockIn = 1'b0; modeSel = 1'b0;
    inStb = 1'b0; inChan = 1'b0; inErr = 1'b0; inData = '0;
    n = 0; fmt = 1'b0;
    held[0] = '0; held[1] = '0; sent[0] = '0; sent[1] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 bclk", bclkOut, 1'b0);
    chk("R10 lrck", lrckOut, 1'b1);
    chk("R10 sdata", sdataOut, 1'b0);
    chk("R10 mclk384", mclk384Out, 1'b0);
    chk("R10 mclk256", mclk256Out, 1'b0);
    rstN = 1'b1;
    lockIn = 1'b1;
    modeSel = 1'b1;
    for (int c = 0; c < TOTAL; c++) begin
      int s;
      s = c / 384;
      inStb  = (c % 384 == 100);
      inChan = s[0];
      inData = 20'($urandom);
      inErr  = (s % 7 == 3) || (s % 7 == 4) || (s % 7 == 5);
      if (c == 3000)  modeSel = 1'b0;
      if (c == 9000)  modeSel = 1'b1;
      if (c == 16000) modeSel = 1'b0;
      // R9: unlocked stretch with strobes still arriving
      lockIn = !(c >= 12000 && c < 14100);
      tick();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule